// File: doc/BRIEF.md
# Clock Controller Configuration Register Bank

This block is the software-visible configuration store of a clock controller. It sits on a simple word-addressed bus made of a byte address, a write strobe with write data, and a read strobe, with registered read data and an error flag. It holds the following registers:

- a clock mode word
- two divider words
- two PLL control words
- three clock-gating words
- two power-management words

Every register loads its own reset value, and keeps only the bits that its own write mask lets through. The full contents are driven out on dedicated ports so that downstream clock generation logic can use them directly.

Not every register can be reached in both directions. One power word can only be read, and the other cannot be reached from the bus at all. One offset has no storage behind it and returns a fixed constant. Any access the map does not allow, and any misaligned address, gives a one-cycle error pulse. Such a write is dropped, and such a read returns zero. The decoded window is 4 KiB wide, and the word index is the byte address divided by four.

Top module: `clkctl_regbank`

## Requirements
- R1: After a synchronous active-high reset, the outputs hold these values: mode 0x074B0B7D, divider 0 0xFF870B48, divider 1 0x49FCFE7F, main PLL 0x04001800, serial PLL 0x04043001, all three gating words 0xFFFFFFFF, power 0 0x80209828 and power 1 0x00AA0000. The response outputs are zero.
- R2: A write to word 0 stores the write data ANDed with 0x3B6FDFFF, with bit 26 forced to 1 on every write.
- R3: A write to word 1 stores the data ANDed with 0xFF9F3FFF. Writes to word 4 (main PLL) and word 6 (serial PLL) store the data ANDed with 0xBFFF3FFF.
- R4: Writes to word 2 and to gating words 8, 9 and 10 store all 32 bits. Gating word 8+k drives bits [32k+31:32k] of the gating output.
- R5: A legal read of words 0, 1, 2, 4, 6, 8, 9, 10 or 23 returns that register's value on the read data port one cycle after the strobe. In any cycle without such a response, the read data is zero.
- R6: Word 18 has no storage. Reading it returns 0x00004040 without an error, and writing it raises the error and changes nothing.
- R7: Word 23 (power 0) can be read, but a write to it is dropped and raises the error. Power 1 has no bus offset and keeps its reset value.
- R8: Any read or write to an aligned word outside the sets above raises the error, changes no register, and a read returns zero.
- R9: An address whose two low bits are not zero is an error for both reads and writes, with no register change and zero read data.
- R10: When a read and a write to the same register fall in the same cycle, the read returns the value held before the write, and the write takes effect on that edge.
- R11: The error flag is high for exactly the one cycle after an illegal strobe, lined up with the read response, and low after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered one-cycle error flag |
| cfg_mode | output | 32 | Clock mode register |
| cfg_div0 | output | 32 | Divider register 0 |
| cfg_div1 | output | 32 | Divider register 1 |
| cfg_pll_main | output | 32 | Main PLL control |
| cfg_pll_ser | output | 32 | Serial PLL control |
| cfg_gate | output | 96 | Three gating words, word 8 in the low bits |
| cfg_pwr0 | output | 32 | Power control 0 |
| cfg_pwr1 | output | 32 | Power control 1 |

## Verification
A read and a write share one address, so the collision of interest is a read of a register in the same cycle that the register is being written.

The bench asserts both strobes on word 2 with new data. It expects the response to carry the old contents, and a following read to return the new value.

It also strobes both directions on word 23 together. There the read part is legal and the write part is not, so the bench expects the register's value together with an error pulse, and an unchanged power output.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned DW      = 32;
    localparam int unsigned N_GATE  = 3;
    localparam int unsigned GIDX_W  = (N_GATE > 1) ? $clog2(N_GATE) : 1;

    // word indices (byte offset / 4)
    localparam int unsigned WI_MODE  = 0;
    localparam int unsigned WI_DIV0  = 1;
    localparam int unsigned WI_DIV1  = 2;
    localparam int unsigned WI_PLLM  = 4;
    localparam int unsigned WI_PLLS  = 6;
    localparam int unsigned WI_GATE0 = 8;
    localparam int unsigned WI_CONST = 18;
    localparam int unsigned WI_PWR0  = 23;

    localparam logic [DW-1:0] RST_MODE  = 32'h074B_0B7D;
    localparam logic [DW-1:0] RST_DIV0  = 32'hFF87_0B48;
    localparam logic [DW-1:0] RST_DIV1  = 32'h49FC_FE7F;
    localparam logic [DW-1:0] RST_PLLM  = 32'h0400_1800;
    localparam logic [DW-1:0] RST_PLLS  = 32'h0404_3001;
    localparam logic [DW-1:0] RST_GATE  = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] RST_PWR0  = 32'h8020_9828;
    localparam logic [DW-1:0] RST_PWR1  = 32'h00AA_0000;

    localparam logic [DW-1:0] MASK_MODE = 32'h3B6F_DFFF;
    localparam logic [DW-1:0] MASK_DIV0 = 32'hFF9F_3FFF;
    localparam logic [DW-1:0] MASK_PLL  = 32'hBFFF_3FFF;
    localparam logic [DW-1:0] MASK_FULL = 32'hFFFF_FFFF;
    localparam int unsigned   FORCE_BIT = 26;
    localparam logic [DW-1:0] CONST_RD  = 32'h0000_4040;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIV0,
        SEL_DIV1,
        SEL_PLLM,
        SEL_PLLS,
        SEL_GATE,
        SEL_CONST,
        SEL_PWR0
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [GIDX_W-1:0] gidx;
        logic              rd_ok;
        logic              wr_ok;
    } dec_t;

    typedef struct packed {
        logic [DW-1:0]             mode;
        logic [DW-1:0]             div0;
        logic [DW-1:0]             div1;
        logic [DW-1:0]             pllm;
        logic [DW-1:0]             plls;
        logic [N_GATE-1:0][DW-1:0] gate;
        logic [DW-1:0]             pwr0;
        logic [DW-1:0]             pwr1;
    } clk_regs_t;

    // Classify one word index; misaligned addresses map to nothing.
    function automatic dec_t decode_word(int unsigned w, logic aligned);
        dec_t d;
        d.sel   = SEL_NONE;
        d.gidx  = '0;
        d.rd_ok = 1'b0;
        d.wr_ok = 1'b0;
        if (aligned) begin
            if (w == WI_MODE) begin
                d.sel = SEL_MODE; d.rd_ok = 1'b1; d.wr_ok = 1'b1;
            end else if (w == WI_DIV0) begin
                d.sel = SEL_DIV0; d.rd_ok = 1'b1; d.wr_ok = 1'b1;
            end else if (w == WI_DIV1) begin
                d.sel = SEL_DIV1; d.rd_ok = 1'b1; d.wr_ok = 1'b1;
            end else if (w == WI_PLLM) begin
                d.sel = SEL_PLLM; d.rd_ok = 1'b1; d.wr_ok = 1'b1;
            end else if (w == WI_PLLS) begin
                d.sel = SEL_PLLS; d.rd_ok = 1'b1; d.wr_ok = 1'b1;
            end else if (w >= WI_GATE0 && w < WI_GATE0 + N_GATE) begin
                d.sel   = SEL_GATE;
                d.gidx  = GIDX_W'(w - WI_GATE0);
                d.rd_ok = 1'b1;
                d.wr_ok = 1'b1;
            end else if (w == WI_CONST) begin
                d.sel = SEL_CONST; d.rd_ok = 1'b1;
            end else if (w == WI_PWR0) begin
                d.sel = SEL_PWR0; d.rd_ok = 1'b1;
            end
        end
        return d;
    endfunction

    // Value a write leaves in the selected register.
    function automatic logic [DW-1:0] store_value(reg_sel_e sel, logic [DW-1:0] d);
        logic [DW-1:0] v;
        unique case (sel)
            SEL_MODE: begin
                v = d & MASK_MODE;
                v[FORCE_BIT] = 1'b1;
            end
            SEL_DIV0:          v = d & MASK_DIV0;
            SEL_PLLM, SEL_PLLS: v = d & MASK_PLL;
            default:           v = d & MASK_FULL;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec
    import clkctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    always_comb begin
        widx    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        dec     = decode_word(int'(widx), aligned);
    end
endmodule

// File: rtl/clkctl_store.sv
module clkctl_store
    import clkctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [GIDX_W-1:0] gidx,
    input  logic [DW-1:0] wdata,
    output clk_regs_t     regs
);
    logic [DW-1:0]             mode_q, div0_q, div1_q, pllm_q, plls_q, pwr0_q, pwr1_q;
    logic [N_GATE-1:0][DW-1:0] gate_q;
    logic [DW-1:0]             wval;

    always_comb wval = store_value(sel, wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RST_MODE;
            div0_q <= RST_DIV0;
            div1_q <= RST_DIV1;
            pllm_q <= RST_PLLM;
            plls_q <= RST_PLLS;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: mode_q <= wval;
                SEL_DIV0: div0_q <= wval;
                SEL_DIV1: div1_q <= wval;
                SEL_PLLM: pllm_q <= wval;
                SEL_PLLS: plls_q <= wval;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_GATE; g++) begin : g_gate
        always_ff @(posedge clk) begin
            if (rst) begin
                gate_q[g] <= RST_GATE;
            end else if (wr_en && sel == SEL_GATE && gidx == GIDX_W'(g)) begin
                gate_q[g] <= wval;
            end
        end
    end

    // power words have no write path; they only take their reset values
    always_ff @(posedge clk) begin
        if (rst) begin
            pwr0_q <= RST_PWR0;
            pwr1_q <= RST_PWR1;
        end
    end

    always_comb begin
        regs.mode = mode_q;
        regs.div0 = div0_q;
        regs.div1 = div1_q;
        regs.pllm = pllm_q;
        regs.plls = plls_q;
        regs.gate = gate_q;
        regs.pwr0 = pwr0_q;
        regs.pwr1 = pwr1_q;
    end
endmodule

// File: rtl/clkctl_resp.sv
module clkctl_resp
    import clkctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic          wr,
    input  dec_t          dec,
    input  clk_regs_t     regs,
    output logic [DW-1:0] rdata,
    output logic          err
);
    logic [DW-1:0] mux_val;
    logic          bad;

    always_comb begin
        unique case (dec.sel)
            SEL_MODE:  mux_val = regs.mode;
            SEL_DIV0:  mux_val = regs.div0;
            SEL_DIV1:  mux_val = regs.div1;
            SEL_PLLM:  mux_val = regs.pllm;
            SEL_PLLS:  mux_val = regs.plls;
            SEL_GATE:  mux_val = regs.gate[dec.gidx];
            SEL_CONST: mux_val = CONST_RD;
            SEL_PWR0:  mux_val = regs.pwr0;
            default:   mux_val = '0;
        endcase
        bad = (rd && !dec.rd_ok) || (wr && !dec.wr_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= (rd && dec.rd_ok) ? mux_val : '0;
            err   <= bad;
        end
    end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [31:0]              bus_wdata,
    input  logic                     bus_rd,
    output logic [31:0]              bus_rdata,
    output logic                     bus_err,
    output logic [31:0]              cfg_mode,
    output logic [31:0]              cfg_div0,
    output logic [31:0]              cfg_div1,
    output logic [31:0]              cfg_pll_main,
    output logic [31:0]              cfg_pll_ser,
    output logic [N_GATE*32-1:0]     cfg_gate,
    output logic [31:0]              cfg_pwr0,
    output logic [31:0]              cfg_pwr1
);
    dec_t      dec;
    clk_regs_t regs;

    clkctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    clkctl_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && dec.wr_ok),
        .sel   (dec.sel),
        .gidx  (dec.gidx),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    clkctl_resp u_resp (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .dec   (dec),
        .regs  (regs),
        .rdata (bus_rdata),
        .err   (bus_err)
    );

    always_comb begin
        cfg_mode     = regs.mode;
        cfg_div0     = regs.div0;
        cfg_div1     = regs.div1;
        cfg_pll_main = regs.pllm;
        cfg_pll_ser  = regs.plls;
        cfg_gate     = regs.gate;
        cfg_pwr0     = regs.pwr0;
        cfg_pwr1     = regs.pwr1;
    end
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [31:0]       cfg_mode,
    input logic [31:0]       cfg_div1,
    input logic [95:0]       cfg_gate,
    input logic [31:0]       cfg_pwr0,
    input logic [31:0]       cfg_pwr1
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    AST_MODE_FORCED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h000) |=> (cfg_mode == (($past(bus_wdata) & 32'h3B6F_DFFF) | 32'h0400_0000))); // R2

    AST_GATE_FULL: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h020) |=> (cfg_gate[31:0] == $past(bus_wdata))); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !bus_wr) |=> (!bus_err && bus_rdata == 32'h0)); // R11

    AST_CONST_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 12'h048) |=> (bus_rdata == 32'h0000_4040 && !bus_err)); // R6

    AST_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_addr[1:0] != 2'b00) |=>
            (bus_err && bus_rdata == 32'h0 && $stable(cfg_mode) && $stable(cfg_div1) && $stable(cfg_gate))); // R9

    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |=> ($stable(cfg_pwr0) && $stable(cfg_pwr1))); // R7
endmodule

bind clkctl_regbank clkctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .cfg_mode  (cfg_mode),
    .cfg_div1  (cfg_div1),
    .cfg_gate  (cfg_gate),
    .cfg_pwr0  (cfg_pwr0),
    .cfg_pwr1  (cfg_pwr1)
);

// File: tb/clkctl_regbank_tb_top.sv
`timescale 1ns/1ps
module clkctl_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] cfg_mode, cfg_div0, cfg_div1, cfg_pll_main, cfg_pll_ser, cfg_pwr0, cfg_pwr1;
    logic [95:0] cfg_gate;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    clkctl_regbank dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .cfg_mode(cfg_mode), .cfg_div0(cfg_div0), .cfg_div1(cfg_div1),
        .cfg_pll_main(cfg_pll_main), .cfg_pll_ser(cfg_pll_ser), .cfg_gate(cfg_gate),
        .cfg_pwr0(cfg_pwr0), .cfg_pwr1(cfg_pwr1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, response is sampled at the next falling edge
    task automatic access(input logic rd, input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 mode", cfg_mode, 32'h074B0B7D);
        chk("R1 div0", cfg_div0, 32'hFF870B48);
        chk("R1 div1", cfg_div1, 32'h49FCFE7F);
        chk("R1 pllm", cfg_pll_main, 32'h04001800);
        chk("R1 plls", cfg_pll_ser, 32'h04043001);
        for (int k = 0; k < 3; k++) chk("R1 gate", cfg_gate[32*k +: 32], 32'hFFFFFFFF);
        chk("R1 pwr0", cfg_pwr0, 32'h80209828);
        chk("R1 pwr1", cfg_pwr1, 32'h00AA0000);
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 err", 32'(bus_err), 32'h0);
    endtask

    task automatic t_mode;
        access(1'b0, 1'b1, 12'h000, 32'h0000_0000);
        chk("R2 zero write", cfg_mode, 32'h04000000);
        access(1'b0, 1'b1, 12'h000, 32'hFFFF_FFFF);
        chk("R2 ones write", cfg_mode, 32'h3F6FDFFF);
        access(1'b1, 1'b0, 12'h000, 32'h0);
        chk("R5 mode read", bus_rdata, 32'h3F6FDFFF);
        chk("R5 mode err", 32'(bus_err), 32'h0);
    endtask

    task automatic t_masks;
        access(1'b0, 1'b1, 12'h004, 32'hFFFF_FFFF);
        chk("R3 div0", cfg_div0, 32'hFF9F3FFF);
        access(1'b0, 1'b1, 12'h010, 32'hFFFF_FFFF);
        chk("R3 pllm", cfg_pll_main, 32'hBFFF3FFF);
        access(1'b0, 1'b1, 12'h018, 32'hFFFF_FFFF);
        chk("R3 plls", cfg_pll_ser, 32'hBFFF3FFF);
        access(1'b1, 1'b0, 12'h018, 32'h0);
        chk("R5 plls read", bus_rdata, 32'hBFFF3FFF);
    endtask

    task automatic t_full;
        access(1'b0, 1'b1, 12'h020, 32'hA5A5_0001);
        access(1'b0, 1'b1, 12'h024, 32'h5A5A_0002);
        access(1'b0, 1'b1, 12'h028, 32'h0000_0003);
        chk("R4 gate0", cfg_gate[31:0], 32'hA5A50001);
        chk("R4 gate1", cfg_gate[63:32], 32'h5A5A0002);
        chk("R4 gate2", cfg_gate[95:64], 32'h00000003);
        access(1'b1, 1'b0, 12'h024, 32'h0);
        chk("R4 gate1 read", bus_rdata, 32'h5A5A0002);
        access(1'b0, 1'b1, 12'h008, 32'hDEAD_BEEF);
        chk("R4 div1", cfg_div1, 32'hDEADBEEF);
    endtask

    task automatic t_const;
        access(1'b1, 1'b0, 12'h048, 32'h0);
        chk("R6 const read", bus_rdata, 32'h00004040);
        chk("R6 const err", 32'(bus_err), 32'h0);
        access(1'b0, 1'b1, 12'h048, 32'h1234_5678);
        chk("R6 const write err", 32'(bus_err), 32'h1);
        access(1'b1, 1'b0, 12'h048, 32'h0);
        chk("R6 const unchanged", bus_rdata, 32'h00004040);
    endtask

    task automatic t_pwr;
        access(1'b0, 1'b1, 12'h05C, 32'h0);
        chk("R7 pwr0 write err", 32'(bus_err), 32'h1);
        chk("R7 pwr0 kept", cfg_pwr0, 32'h80209828);
        access(1'b1, 1'b0, 12'h05C, 32'h0);
        chk("R7 pwr0 read", bus_rdata, 32'h80209828);
        chk("R7 pwr0 read err", 32'(bus_err), 32'h0);
        chk("R7 pwr1 kept", cfg_pwr1, 32'h00AA0000);
    endtask

    task automatic t_unmapped;
        logic [31:0] m, d1;
        m = cfg_mode; d1 = cfg_div1;
        access(1'b0, 1'b1, 12'h00C, 32'h0);
        chk("R8 write err", 32'(bus_err), 32'h1);
        chk("R8 mode kept", cfg_mode, m);
        chk("R8 div1 kept", cfg_div1, d1);
        access(1'b1, 1'b0, 12'h014, 32'h0);
        chk("R8 read err", 32'(bus_err), 32'h1);
        chk("R8 read zero", bus_rdata, 32'h0);
        access(1'b1, 1'b0, 12'hFFC, 32'h0);
        chk("R8 top word err", 32'(bus_err), 32'h1);
        @(negedge clk);
        chk("R11 err drops", 32'(bus_err), 32'h0);
        chk("R5 idle zero", bus_rdata, 32'h0);
    endtask

    task automatic t_misaligned;
        logic [31:0] m;
        m = cfg_mode;
        access(1'b0, 1'b1, 12'h002, 32'h0);
        chk("R9 write err", 32'(bus_err), 32'h1);
        chk("R9 mode kept", cfg_mode, m);
        access(1'b1, 1'b0, 12'h005, 32'h0);
        chk("R9 read err", 32'(bus_err), 32'h1);
        chk("R9 read zero", bus_rdata, 32'h0);
    endtask

    task automatic t_collide;
        access(1'b1, 1'b1, 12'h008, 32'h1234_5678);
        chk("R10 old value", bus_rdata, 32'hDEADBEEF);
        chk("R10 no err", 32'(bus_err), 32'h0);
        chk("R10 new stored", cfg_div1, 32'h12345678);
        access(1'b1, 1'b0, 12'h008, 32'h0);
        chk("R10 read new", bus_rdata, 32'h12345678);
        access(1'b1, 1'b1, 12'h05C, 32'h0);
        chk("R10 pwr0 data", bus_rdata, 32'h80209828);
        chk("R10 pwr0 err", 32'(bus_err), 32'h1);
        chk("R10 pwr0 kept", cfg_pwr0, 32'h80209828);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode();
        t_masks();
        t_full();
        t_const();
        t_pwr();
        t_unmapped();
        t_misaligned();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule